// File: doc/BRIEF.md
# Load/Store Address Generator

This block forms the byte address of one load or store and, for the modifying forms, the value the base register takes afterwards. Decode hands it the base register's contents and its identity (register side and number), the access size, an address form, a modify code, a constant field and the contents of an index register. It also receives a per-register selection that marks which of the eight wrap-capable registers use circular addressing, together with one block-size field.

The result has four parts: the effective address, a write-back strobe, the new base value, and an illegal-request flag. The register file uses the strobe and new base value to update the base register. The load/store port uses the address. Every offset is scaled by the access size before it is added to the base. Circular registers wrap within an aligned power-of-two block. An optional output register stage, selected by a parameter and enabled by default, gives the block a latency of one cycle.

Top module: `agu_lsu`

## Requirements
- R1: The offset is shifted left by the size code before it is added to or subtracted from the base. Size code 0 is byte (x1), 1 is halfword (x2), 2 is word (x4) and 3 is doubleword (x8).
- R2: Form code 0 is register-indirect. Its offset is 0 for the no-modify codes and 1 otherwise, so it steps one access size. Form 1 uses the low 5 bits of the constant field, zero-extended. Form 2 uses the full index-register value. Form 3 uses the 15-bit constant.
- R3: Modify codes are: 0 no-modify plus, 1 no-modify minus, 2 pre-increment, 3 pre-decrement, 4 post-increment, 5 post-decrement. No-modify and pre forms output base±offset as the address. Post forms output the unchanged base as the address.
- R4: The write-back strobe is 1 only for modify codes 2 to 5 on a legal request that is not form 3. The new base is then base±offset. Whenever the strobe is 0, the new base equals the input base.
- R5: Form 3 is legal only with register B14 or B15 (side bit 1, number 14 or 15). It always adds its offset, ignores the modify code, and never writes back.
- R6: A request is illegal if it uses form 3 with any other register, or uses modify code 6 or 7. An illegal request raises the flag, drops the strobe, and returns the input base as both the address and the new base.
- R7: Circular addressing applies only to registers 4 to 7 of either side. Selection bit `side*4 + (number-4)` enables it. Every other register is linear whatever the selection bits hold.
- R8: In circular mode the block is 2^(N+1) bytes, where N is the 5-bit size field. Result bits inside the block come from the sum. Bits above the block are copied from the base. This applies to both the address and the new base.
- R9: With the output stage enabled, the results for inputs present at a rising edge appear after that edge. A synchronous active-high reset clears all four outputs to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| base_i | input | 32 | Base register contents |
| base_side_i | input | 1 | Register side of the base (0 = A, 1 = B) |
| base_num_i | input | 5 | Register number of the base |
| size_i | input | 2 | Access size code |
| form_i | input | 2 | Address form code |
| mod_i | input | 3 | Modify code |
| kfield_i | input | 15 | Unsigned constant field |
| index_i | input | 32 | Index register contents |
| circ_sel_i | input | 8 | Circular enables for A4-A7 (bits 0-3) and B4-B7 (bits 4-7) |
| blk_n_i | input | 5 | Circular block-size field N |
| addr_o | output | 32 | Effective byte address |
| wb_o | output | 1 | Base write-back strobe |
| new_base_o | output | 32 | Updated base value |
| illegal_o | output | 1 | Illegal request flag |

## Verification
The tests cover each form with every modify code and size. This shows whether the address comes from the old or the updated base, and whether the offset is scaled and carries the right sign. Circular requests on wrap-capable registers are placed so that they cross a block edge in both directions. The same registers are also run with the selection bit cleared, and registers 0 to 3 are run with all selection bits set; this separates the wrap itself from its gating by register and selection bit. The 15-bit form is applied to B14, B15 and several non-designated registers, and the reserved modify codes are applied as well; these show that legality is decided correctly and that write-back is suppressed. Seeded random requests that mix all fields follow these directed cases.

// File: rtl/agu_pkg.sv
package agu_pkg;

  typedef enum logic [1:0] {
    FORM_IND = 2'd0,
    FORM_K5  = 2'd1,
    FORM_IDX = 2'd2,
    FORM_K15 = 2'd3
  } form_e;

  typedef enum logic [2:0] {
    MOD_NONE_P = 3'd0,
    MOD_NONE_M = 3'd1,
    MOD_PRE_I  = 3'd2,
    MOD_PRE_D  = 3'd3,
    MOD_POST_I = 3'd4,
    MOD_POST_D = 3'd5,
    MOD_RSV6   = 3'd6,
    MOD_RSV7   = 3'd7
  } mod_e;

  typedef struct packed {
    logic legal;
    logic modify;
    logic subtract;
    logic post;
    logic circ;
  } agu_ctl_t;

endpackage

// File: rtl/agu_decode.sv
module agu_decode
  import agu_pkg::*;
#(
  parameter int NUM_W   = 5,
  parameter int CIRC_LO = 4,
  parameter int CIRC_N  = 4
) (
  input  logic [1:0]        form_i,
  input  logic [2:0]        mod_i,
  input  logic              side_i,
  input  logic [NUM_W-1:0]  num_i,
  input  logic [2*CIRC_N-1:0] circ_sel_i,
  output agu_ctl_t          ctl_o
);
  localparam int SEL_W = $clog2(CIRC_N);

  form_e form;
  mod_e  md;
  logic  k15_reg_ok;
  logic  in_circ_range;
  logic [SEL_W:0] sel_bit;

  always_comb begin
    form = form_e'(form_i);
    md   = mod_e'(mod_i);
    k15_reg_ok    = side_i && ((num_i == NUM_W'(14)) || (num_i == NUM_W'(15)));
    in_circ_range = (num_i >= NUM_W'(CIRC_LO)) && (num_i < NUM_W'(CIRC_LO + CIRC_N));
    sel_bit       = {side_i, SEL_W'(num_i - NUM_W'(CIRC_LO))};

    ctl_o.legal    = (md != MOD_RSV6) && (md != MOD_RSV7) &&
                     ((form != FORM_K15) || k15_reg_ok);
    ctl_o.modify   = ctl_o.legal && (form != FORM_K15) &&
                     (md inside {MOD_PRE_I, MOD_PRE_D, MOD_POST_I, MOD_POST_D});
    ctl_o.subtract = (form != FORM_K15) &&
                     (md inside {MOD_NONE_M, MOD_PRE_D, MOD_POST_D});
    ctl_o.post     = (form != FORM_K15) && (md inside {MOD_POST_I, MOD_POST_D});
    ctl_o.circ     = (form != FORM_K15) && in_circ_range && circ_sel_i[sel_bit];
  end
endmodule

// File: rtl/agu_offset.sv
module agu_offset
  import agu_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int K_W    = 15,
  parameter int K5_W   = 5
) (
  input  logic [1:0]        form_i,
  input  logic [2:0]        mod_i,
  input  logic [1:0]        size_i,
  input  logic [K_W-1:0]    kfield_i,
  input  logic [ADDR_W-1:0] index_i,
  output logic [ADDR_W-1:0] step_o
);
  logic [ADDR_W-1:0] raw;

  always_comb begin
    unique case (form_e'(form_i))
      FORM_IND: raw = (mod_e'(mod_i) inside {MOD_NONE_P, MOD_NONE_M}) ?
                      '0 : ADDR_W'(1);
      FORM_K5:  raw = ADDR_W'(kfield_i[K5_W-1:0]);
      FORM_IDX: raw = index_i;
      default:  raw = ADDR_W'(kfield_i);
    endcase
    step_o = raw << size_i;
  end
endmodule

// File: rtl/agu_wrap_add.sv
module agu_wrap_add #(
  parameter int ADDR_W = 32,
  parameter int BLK_W  = 5
) (
  input  logic [ADDR_W-1:0] base_i,
  input  logic [ADDR_W-1:0] step_i,
  input  logic              subtract_i,
  input  logic              circ_i,
  input  logic [BLK_W-1:0]  blk_n_i,
  output logic [ADDR_W-1:0] sum_o
);
  localparam int SH_W = BLK_W + 1;

  logic [ADDR_W-1:0] lin;
  logic [ADDR_W:0]   span;
  logic [ADDR_W-1:0] mask;

  always_comb begin
    lin  = subtract_i ? (base_i - step_i) : (base_i + step_i);
    span = ({{ADDR_W{1'b0}}, 1'b1} << (SH_W'(blk_n_i) + SH_W'(1))) - (ADDR_W+1)'(1);
    mask = span[ADDR_W-1:0];
    sum_o = circ_i ? ((base_i & ~mask) | (lin & mask)) : lin;
  end
endmodule

// File: rtl/agu_lsu.sv
module agu_lsu
  import agu_pkg::*;
#(
  parameter int ADDR_W  = 32,
  parameter int NUM_W   = 5,
  parameter int K_W     = 15,
  parameter int BLK_W   = 5,
  parameter int CIRC_N  = 4,
  parameter bit OUT_REG = 1'b1
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [ADDR_W-1:0]    base_i,
  input  logic                 base_side_i,
  input  logic [NUM_W-1:0]     base_num_i,
  input  logic [1:0]           size_i,
  input  logic [1:0]           form_i,
  input  logic [2:0]           mod_i,
  input  logic [K_W-1:0]       kfield_i,
  input  logic [ADDR_W-1:0]    index_i,
  input  logic [2*CIRC_N-1:0]  circ_sel_i,
  input  logic [BLK_W-1:0]     blk_n_i,
  output logic [ADDR_W-1:0]    addr_o,
  output logic                 wb_o,
  output logic [ADDR_W-1:0]    new_base_o,
  output logic                 illegal_o
);
  agu_ctl_t          ctl;
  logic [ADDR_W-1:0] step;
  logic [ADDR_W-1:0] sum;
  logic [ADDR_W-1:0] addr_c;
  logic [ADDR_W-1:0] nb_c;
  logic              wb_c;
  logic              ill_c;

  agu_decode #(.NUM_W(NUM_W), .CIRC_LO(4), .CIRC_N(CIRC_N)) i_dec (
    .form_i     (form_i),
    .mod_i      (mod_i),
    .side_i     (base_side_i),
    .num_i      (base_num_i),
    .circ_sel_i (circ_sel_i),
    .ctl_o      (ctl)
  );

  agu_offset #(.ADDR_W(ADDR_W), .K_W(K_W), .K5_W(5)) i_off (
    .form_i   (form_i),
    .mod_i    (mod_i),
    .size_i   (size_i),
    .kfield_i (kfield_i),
    .index_i  (index_i),
    .step_o   (step)
  );

  agu_wrap_add #(.ADDR_W(ADDR_W), .BLK_W(BLK_W)) i_add (
    .base_i     (base_i),
    .step_i     (step),
    .subtract_i (ctl.subtract),
    .circ_i     (ctl.circ),
    .blk_n_i    (blk_n_i),
    .sum_o      (sum)
  );

  always_comb begin
    ill_c  = !ctl.legal;
    wb_c   = ctl.modify;
    addr_c = (ill_c || ctl.post) ? base_i : sum;
    nb_c   = wb_c ? sum : base_i;
  end

  generate
    if (OUT_REG) begin : g_reg
      always_ff @(posedge clk) begin
        if (rst) begin
          addr_o     <= '0;
          wb_o       <= 1'b0;
          new_base_o <= '0;
          illegal_o  <= 1'b0;
        end else begin
          addr_o     <= addr_c;
          wb_o       <= wb_c;
          new_base_o <= nb_c;
          illegal_o  <= ill_c;
        end
      end
    end else begin : g_comb
      assign addr_o     = addr_c;
      assign wb_o       = wb_c;
      assign new_base_o = nb_c;
      assign illegal_o  = ill_c;
    end
  endgenerate
endmodule

// File: rtl/agu_lsu_chk.sv
module agu_lsu_chk #(
  parameter int ADDR_W  = 32,
  parameter int NUM_W   = 5,
  parameter int BLK_W   = 5,
  parameter int CIRC_N  = 4,
  parameter bit OUT_REG = 1'b1
) (
  input logic                clk,
  input logic                rst,
  input logic [ADDR_W-1:0]   base_i,
  input logic                base_side_i,
  input logic [NUM_W-1:0]    base_num_i,
  input logic [1:0]          form_i,
  input logic [2:0]          mod_i,
  input logic [2*CIRC_N-1:0] circ_sel_i,
  input logic [BLK_W-1:0]    blk_n_i,
  input logic [ADDR_W-1:0]   addr_o,
  input logic                wb_o,
  input logic [ADDR_W-1:0]   new_base_o,
  input logic                illegal_o
);
  logic [ADDR_W-1:0]   c_base;
  logic                c_side;
  logic [NUM_W-1:0]    c_num;
  logic [1:0]          c_form;
  logic [2:0]          c_mod;
  logic [2*CIRC_N-1:0] c_sel;
  logic [BLK_W-1:0]    c_blk;
  logic                seen;

  generate
    if (OUT_REG) begin : g_cap
      always_ff @(posedge clk) begin
        c_base <= base_i;  c_side <= base_side_i; c_num <= base_num_i;
        c_form <= form_i;  c_mod  <= mod_i;
        c_sel  <= circ_sel_i; c_blk <= blk_n_i;
        seen   <= !rst;
      end
    end else begin : g_pass
      assign c_base = base_i;  assign c_side = base_side_i;
      assign c_num  = base_num_i; assign c_form = form_i;
      assign c_mod  = mod_i;   assign c_sel  = circ_sel_i;
      assign c_blk  = blk_n_i; assign seen   = 1'b1;
    end
  endgenerate

  logic              c_circ;
  logic [ADDR_W:0]   c_span;
  logic [ADDR_W-1:0] c_mask;
  always_comb begin
    c_circ = (c_form != 2'd3) && (c_num >= NUM_W'(4)) && (c_num <= NUM_W'(7)) &&
             c_sel[{c_side, c_num[1:0]}];
    c_span = ({{ADDR_W{1'b0}}, 1'b1} << ({1'b0, c_blk} + 6'd1)) - (ADDR_W+1)'(1);
    c_mask = c_span[ADDR_W-1:0];
  end

  AST_ILLEGAL_NO_WB: assert property (@(posedge clk) disable iff (rst)
    illegal_o |-> !wb_o); // R6

  AST_WB_ONLY_MODIFY: assert property (@(posedge clk) disable iff (rst)
    (seen && wb_o) |-> (c_mod >= 3'd2 && c_mod <= 3'd5 && c_form != 2'd3)); // R4

  AST_NOWB_KEEPS_BASE: assert property (@(posedge clk) disable iff (rst)
    (seen && !wb_o) |-> (new_base_o == c_base)); // R4

  AST_POST_OLD_BASE: assert property (@(posedge clk) disable iff (rst)
    (seen && c_form != 2'd3 && (c_mod == 3'd4 || c_mod == 3'd5)) |-> (addr_o == c_base)); // R3

  AST_PRE_ADDR_UPDATED: assert property (@(posedge clk) disable iff (rst)
    (seen && wb_o && (c_mod == 3'd2 || c_mod == 3'd3)) |-> (addr_o == new_base_o)); // R3

  AST_K15_NO_WB: assert property (@(posedge clk) disable iff (rst)
    (seen && c_form == 2'd3) |-> !wb_o); // R5

  AST_CIRC_UPPER_KEPT: assert property (@(posedge clk) disable iff (rst)
    (seen && c_circ && !illegal_o) |-> (((addr_o ^ c_base) & ~c_mask) == '0)); // R8

  AST_RESET_CLEARS: assert property (@(posedge clk)
    (OUT_REG && $past(rst)) |-> (!wb_o && !illegal_o && addr_o == '0)); // R9
endmodule

bind agu_lsu agu_lsu_chk #(
  .ADDR_W(ADDR_W), .NUM_W(NUM_W), .BLK_W(BLK_W), .CIRC_N(CIRC_N), .OUT_REG(OUT_REG)
) i_agu_lsu_chk (
  .clk(clk), .rst(rst), .base_i(base_i), .base_side_i(base_side_i),
  .base_num_i(base_num_i), .form_i(form_i), .mod_i(mod_i),
  .circ_sel_i(circ_sel_i), .blk_n_i(blk_n_i), .addr_o(addr_o), .wb_o(wb_o),
  .new_base_o(new_base_o), .illegal_o(illegal_o)
);

// File: tb/test_agu_lsu.sv
module test_agu_lsu;
  logic        clk = 1'b0;
  logic        rst;
  logic [31:0] base_i;
  logic        base_side_i;
  logic [4:0]  base_num_i;
  logic [1:0]  size_i;
  logic [1:0]  form_i;
  logic [2:0]  mod_i;
  logic [14:0] kfield_i;
  logic [31:0] index_i;
  logic [7:0]  circ_sel_i;
  logic [4:0]  blk_n_i;
  logic [31:0] addr_o;
  logic        wb_o;
  logic [31:0] new_base_o;
  logic        illegal_o;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #4 clk = ~clk;

  agu_lsu i_agu_lsu (
    .clk(clk), .rst(rst), .base_i(base_i), .base_side_i(base_side_i),
    .base_num_i(base_num_i), .size_i(size_i), .form_i(form_i), .mod_i(mod_i),
    .kfield_i(kfield_i), .index_i(index_i), .circ_sel_i(circ_sel_i),
    .blk_n_i(blk_n_i), .addr_o(addr_o), .wb_o(wb_o), .new_base_o(new_base_o),
    .illegal_o(illegal_o)
  );

  task automatic model(output logic [31:0] ea, output logic [31:0] nb,
                       output logic wb, output logic il);
    logic [31:0] off, step, raw, res, m;
    logic circ, neg;
    il = (mod_i > 3'd5) ||
         (form_i == 2'd3 && !(base_side_i && (base_num_i == 5'd14 || base_num_i == 5'd15)));
    if (il) begin
      ea = base_i; nb = base_i; wb = 1'b0;
    end else begin
      case (form_i)
        2'd0: off = (mod_i < 3'd2) ? 32'd0 : 32'd1;
        2'd1: off = {27'd0, kfield_i[4:0]};
        2'd2: off = index_i;
        default: off = {17'd0, kfield_i};
      endcase
      step = off * (32'd1 << size_i);
      neg  = (form_i != 2'd3) && mod_i[0];
      raw  = neg ? base_i - step : base_i + step;
      circ = (form_i != 2'd3) && base_num_i >= 5'd4 && base_num_i <= 5'd7 &&
             circ_sel_i[base_side_i*4 + (base_num_i - 5'd4)];
      m    = (blk_n_i == 5'd31) ? 32'hFFFF_FFFF : ((32'd1 << (blk_n_i + 5'd1)) - 32'd1);
      res  = circ ? ((base_i & ~m) | (raw & m)) : raw;
      wb   = (form_i != 2'd3) && mod_i >= 3'd2;
      ea   = (form_i != 2'd3 && mod_i >= 3'd4) ? base_i : res;
      nb   = wb ? res : base_i;
    end
  endtask

  task automatic run(input string tag);
    logic [31:0] ea, nb;
    logic wb, il;
    model(ea, nb, wb, il);
    @(negedge clk);
    checks++;
    if (addr_o !== ea || new_base_o !== nb || wb_o !== wb || illegal_o !== il) begin
      fails++;
      $display("FAIL %s: got addr=%h nb=%h wb=%b ill=%b exp addr=%h nb=%h wb=%b ill=%b",
               tag, addr_o, new_base_o, wb_o, illegal_o, ea, nb, wb, il);
    end
  endtask

  task automatic set(input logic side, input logic [4:0] num, input logic [31:0] b,
                     input logic [1:0] sz, input logic [1:0] fm, input logic [2:0] md,
                     input logic [14:0] k, input logic [31:0] ix,
                     input logic [7:0] cs, input logic [4:0] bn);
    base_side_i = side; base_num_i = num; base_i = b; size_i = sz; form_i = fm;
    mod_i = md; kfield_i = k; index_i = ix; circ_sel_i = cs; blk_n_i = bn;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: got running exp finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    rst = 1'b1;
    set(1'b0, 5'd4, 32'h1234_5678, 2'd2, 2'd1, 3'd2, 15'd9, 32'd0, 8'hFF, 5'd3);
    repeat (3) @(negedge clk);
    checks++;
    if (addr_o !== 32'd0 || wb_o !== 1'b0 || new_base_o !== 32'd0 || illegal_o !== 1'b0) begin
      fails++;
      $display("FAIL R9 reset: got addr=%h wb=%b nb=%h ill=%b exp all zero",
               addr_o, wb_o, new_base_o, illegal_o);
    end
    rst = 1'b0;

    // R1 R3 word pre-increment by constant 9 adds 36 bytes
    set(1'b0, 5'd4, 32'h0000_1000, 2'd2, 2'd1, 3'd2, 15'd9, 32'd0, 8'h00, 5'd0);
    run("R1 word pre-inc k5");
    // R2 register-indirect post-increment byte steps one
    set(1'b0, 5'd2, 32'h0000_0100, 2'd0, 2'd0, 3'd4, 15'd0, 32'd0, 8'h00, 5'd0);
    run("R2 indirect post-inc byte");
    // R2 register-indirect no-modify: address equals base
    set(1'b1, 5'd9, 32'h0000_0200, 2'd3, 2'd0, 3'd0, 15'd7, 32'd0, 8'h00, 5'd0);
    run("R2 indirect no-modify");
    // R3 no-modify minus constant halfword
    set(1'b1, 5'd3, 32'h0000_0400, 2'd1, 2'd1, 3'd1, 15'h7FE3, 32'd0, 8'h00, 5'd0);
    run("R3 no-modify minus k5");
    // R1 doubleword pre-decrement by index
    set(1'b0, 5'd10, 32'h0000_2000, 2'd3, 2'd2, 3'd3, 15'd0, 32'd3, 8'h00, 5'd0);
    run("R1 dword pre-dec index");
    // R4 post-decrement halfword index writes back
    set(1'b1, 5'd1, 32'h0000_3000, 2'd1, 2'd2, 3'd5, 15'd0, 32'd5, 8'h00, 5'd0);
    run("R4 post-dec writes back");
    // R5 constant 15 with B15 and B14, modify code ignored
    set(1'b1, 5'd15, 32'h0001_0000, 2'd2, 2'd3, 3'd3, 15'h7FFF, 32'd0, 8'h00, 5'd0);
    run("R5 k15 on B15");
    set(1'b1, 5'd14, 32'h0002_0000, 2'd0, 2'd3, 3'd4, 15'h0123, 32'd0, 8'hFF, 5'd0);
    run("R5 k15 on B14");
    // R6 illegal: k15 on A14 and B13, reserved modify code
    set(1'b0, 5'd14, 32'h0003_0000, 2'd2, 2'd3, 3'd0, 15'h10, 32'd0, 8'h00, 5'd0);
    run("R6 k15 on A14");
    set(1'b1, 5'd13, 32'h0003_0000, 2'd2, 2'd3, 3'd2, 15'h10, 32'd0, 8'h00, 5'd0);
    run("R6 k15 on B13");
    set(1'b0, 5'd5, 32'h0004_0000, 2'd2, 2'd1, 3'd7, 15'h4, 32'd0, 8'hFF, 5'd2);
    run("R6 reserved modify");
    // R8 circular A5, 16-byte block, wraps upward
    set(1'b0, 5'd5, 32'h0000_100C, 2'd2, 2'd1, 3'd4, 15'd2, 32'd0, 8'h02, 5'd3);
    run("R8 circular post-inc wrap up");
    set(1'b0, 5'd5, 32'h0000_100C, 2'd2, 2'd1, 3'd2, 15'd2, 32'd0, 8'h02, 5'd3);
    run("R8 circular pre-inc wrap up");
    // R8 circular B7, wraps downward
    set(1'b1, 5'd7, 32'h0000_5004, 2'd3, 2'd0, 3'd3, 15'd0, 32'd0, 8'h80, 5'd4);
    run("R8 circular pre-dec wrap down");
    // R7 same request on B7 with bit clear is linear
    set(1'b1, 5'd7, 32'h0000_5004, 2'd3, 2'd0, 3'd3, 15'd0, 32'd0, 8'h7F, 5'd4);
    run("R7 selection bit clear");
    // R7 A3 with all bits set stays linear
    set(1'b0, 5'd3, 32'h0000_100C, 2'd2, 2'd1, 3'd4, 15'd2, 32'd0, 8'hFF, 5'd3);
    run("R7 A3 never circular");
    // R8 largest block is a full wrap
    set(1'b0, 5'd6, 32'hFFFF_FFFC, 2'd2, 2'd0, 3'd2, 15'd0, 32'd0, 8'hFF, 5'd31);
    run("R8 full-size block");

    for (int n = 0; n < 600; n++) begin
      logic [31:0] r;
      r = $urandom();
      set(r[0], (r[3:1] == 3'd0) ? {4'b0111, r[4]} :
                (r[3:1] == 3'd1) ? {3'b001, r[6:5]} : r[9:5],
          $urandom(), r[11:10], r[13:12], (r[16:14] > 3'd6) ? 3'd2 : r[16:14],
          r[31:17], (r[5] ? $urandom() : ($urandom() & 32'hFF)), r[27:20], r[30:26]);
      run("R3 random");
    end

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
  end
endmodule